// File: doc/BRIEF.md
# Producer-Consumer Resource Hazard Table

This block keeps track of memory buffers that a downstream consumer pipeline is still using, so that an upstream producer pipeline can hold off before it touches them. A buffer is named by a resolved 64-bit handle. The handle is opaque and is compared only for equality. The block holds two separate tables.

The general table stores a handle together with a write flag and the timestamp of its last use. Consumer inserts add entries to this table. Producer checks look the table up and stall only on a read/write conflict. A release event retires, in one step, every entry whose timestamp has reached a given value. If an insert finds the general table full, the entry is dropped and a sticky overflow bit is set. The producer then stalls until the table has fully drained.

The exclusive table is simpler. An acquire stalls while the same handle is present, then stores it. An exclusive release removes exactly one entry, the one whose handle matches. Every request interface uses a valid/ready pair. Ready high in a cycle means the request is taken in that cycle. Ready low means it stalls, and the requester holds its inputs until it is taken.

Top module: `res_hazard_tracker`

## Requirements
- R1: After reset both tables are empty and `ovf_status` is 0. Any producer check is ready at once.
- R2: A producer check stalls (`chk_ready` low) only if a general entry has the same handle and either the check or that entry has its write flag at 1. A read against a read passes, and so does a handle that is not in the table.
- R3: A stall caused by an entry ends in the first cycle after the clock edge at which that entry was removed.
- R4: A release with `rel_render` at 1 removes every general entry whose stamp S satisfies S − `rel_stamp` ≤ 0, taken as a signed 32-bit difference. This holds across stamp wraparound. Newer entries stay.
- R5: An accepted insert with a free slot stores its handle, write flag and stamp. An accepted insert into a full general table is not stored, and `ovf_status` is 1 from the next cycle.
- R6: `ovf_status` stays at 1 until a cycle with `ovf_clr` at 1. It reads 0 after that clock edge, unless a new overflow happens in the same cycle, in which case it stays at 1.
- R7: After an overflow, every producer check stalls, whatever its handle, until the general table is empty.
- R8: An insert is not accepted (`ins_ready` low) in any cycle where `chk_valid` is 1. This lets all checks of a command finish before its inserts.
- R9: An acquire stalls while the exclusive table holds the same handle. Otherwise it is accepted and the handle is stored.
- R10: A release with `rel_excl` at 1 removes only the exclusive entry whose handle equals `rel_handle`. Other entries stay.
- R11: An acquire stalls while the exclusive table is full, even if its handle is not present.
- R12: The two tables are independent. Exclusive entries never stall producer checks, and general entries never stall acquires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | Producer check request |
| chk_handle | input | 64 | Handle being checked |
| chk_wr | input | 1 | Check intends to write |
| chk_ready | output | 1 | Check taken this cycle |
| ins_valid | input | 1 | Consumer insert request |
| ins_handle | input | 64 | Handle to insert |
| ins_wr | input | 1 | Inserted use is a write |
| ins_stamp | input | 32 | Timestamp of the use |
| ins_ready | output | 1 | Insert taken this cycle |
| acq_valid | input | 1 | Exclusive acquire request |
| acq_handle | input | 64 | Handle to acquire |
| acq_ready | output | 1 | Acquire taken this cycle |
| rel_valid | input | 1 | Release event |
| rel_render | input | 1 | Event retires general entries by stamp |
| rel_stamp | input | 32 | Current timestamp of the event |
| rel_excl | input | 1 | Event frees one exclusive entry |
| rel_handle | input | 64 | Handle to free from the exclusive table |
| ovf_clr | input | 1 | Clears the overflow bit |
| ovf_status | output | 1 | Sticky overflow bit |

## Verification
A wrong valid bit or stored field in either table has no separate status of its own. It shows up as a wrong ready level on the very next request that names the affected handle: either a check or acquire that should pass but stalls, or a hazard that is let through. A wrong drain flag shows up as checks on unrelated handles stalling, or not stalling, in the cycle after an overflow. A wrong stamp comparison shows up as an entry that survives, or is lost, on the first release whose stamp lies near it across the wrap point. The bench runs a cycle-accurate model of both tables and compares every ready output and the overflow bit in every cycle, so any such divergence is caught within one cycle of its first visible effect.

// File: rtl/rht_pkg.sv
package rht_pkg;
  localparam int unsigned HANDLE_W = 64;
  localparam int unsigned STAMP_W  = 32;

  typedef logic [HANDLE_W-1:0] handle_t;
  typedef logic [STAMP_W-1:0]  stamp_t;

  typedef struct packed {
    handle_t handle;
    logic    wr;
    stamp_t  stamp;
  } gen_entry_t;

  // True when the entry stamp is at or before the limit, in wrapping order.
  function automatic logic stamp_retired(stamp_t entry, stamp_t limit);
    stamp_t diff;
    diff = entry - limit;
    return diff[STAMP_W-1] || (diff == '0);
  endfunction
endpackage

// File: rtl/rht_gen_table.sv
module rht_gen_table
  import rht_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ins_en,
  input  handle_t ins_handle,
  input  logic    ins_wr,
  input  stamp_t  ins_stamp,
  input  logic    rel_en,
  input  stamp_t  rel_stamp,
  input  handle_t q_handle,
  input  logic    q_wr,
  output logic    conflict,
  output logic    empty,
  output logic    drop
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, vld_d, hit, retire, load;
  logic             free_hit;
  logic [IDX_W-1:0] free_idx;

  // lowest free slot
  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    gen_entry_t ent_q;
    assign hit[g]    = vld_q[g] && (ent_q.handle == q_handle) && (ent_q.wr || q_wr);
    assign retire[g] = rel_en && vld_q[g] && stamp_retired(ent_q.stamp, rel_stamp);
    assign load[g]   = ins_en && free_hit && (free_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (load[g]) begin
        ent_q <= '{handle: ins_handle, wr: ins_wr, stamp: ins_stamp};
      end
    end
  end

  always_comb begin
    vld_d = (vld_q & ~retire) | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign conflict = |hit;
  assign empty    = ~|vld_q;
  assign drop     = ins_en && !free_hit;

  // R4
  release_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en && !ins_en |=> $countones(vld_q) <= $past($countones(vld_q)));
  // R5
  insert_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en && free_hit && !rel_en |=> $countones(vld_q) == $past($countones(vld_q)) + 1);
  // R5
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !rel_en |=> vld_q == $past(vld_q));
endmodule

// File: rtl/rht_excl_table.sv
module rht_excl_table
  import rht_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    acq_en,
  input  handle_t acq_handle,
  input  logic    rel_en,
  input  handle_t rel_handle,
  input  handle_t q_handle,
  output logic    hit,
  output logic    full
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, vld_d, match, kill, load;
  logic             free_hit;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    handle_t h_q;
    assign match[g] = vld_q[g] && (h_q == q_handle);
    assign kill[g]  = rel_en && vld_q[g] && (h_q == rel_handle);
    assign load[g]  = acq_en && free_hit && (free_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (load[g]) h_q <= acq_handle;
    end
  end

  always_comb begin
    vld_d = (vld_q & ~kill) | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign hit  = |match;
  assign full = !free_hit;

  // R10
  excl_single_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en && !acq_en |=> $countones(vld_q) + 1 >= $past($countones(vld_q)));
  // R9
  excl_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en && free_hit && !rel_en |=> $countones(vld_q) == $past($countones(vld_q)) + 1);
endmodule

// File: rtl/rht_ovf_ctrl.sv
module rht_ovf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_ev,
  input  logic ovf_clr,
  input  logic tbl_empty,
  output logic ovf_flag,
  output logic drain_pend
);
  logic ovf_d, drain_d;

  always_comb begin
    ovf_d = ovf_flag;
    if (ovf_clr) ovf_d = 1'b0;
    if (ovf_ev)  ovf_d = 1'b1;
    drain_d = drain_pend;
    if (tbl_empty) drain_d = 1'b0;
    if (ovf_ev)    drain_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag   <= 1'b0;
      drain_pend <= 1'b0;
    end else begin
      ovf_flag   <= ovf_d;
      drain_pend <= drain_d;
    end
  end

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_flag);
  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(ovf_clr));
  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_pend && !tbl_empty |=> drain_pend);
endmodule

// File: rtl/res_hazard_tracker.sv
module res_hazard_tracker
  import rht_pkg::*;
#(
  parameter int unsigned GEN_DEPTH  = 16,
  parameter int unsigned EXCL_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chk_valid,
  input  logic [HANDLE_W-1:0] chk_handle,
  input  logic                chk_wr,
  output logic                chk_ready,
  input  logic                ins_valid,
  input  logic [HANDLE_W-1:0] ins_handle,
  input  logic                ins_wr,
  input  logic [STAMP_W-1:0]  ins_stamp,
  output logic                ins_ready,
  input  logic                acq_valid,
  input  logic [HANDLE_W-1:0] acq_handle,
  output logic                acq_ready,
  input  logic                rel_valid,
  input  logic                rel_render,
  input  logic [STAMP_W-1:0]  rel_stamp,
  input  logic                rel_excl,
  input  logic [HANDLE_W-1:0] rel_handle,
  input  logic                ovf_clr,
  output logic                ovf_status
);
  logic gen_conflict, gen_empty, gen_drop;
  logic ex_hit, ex_full;
  logic drain_pend;

  assign chk_ready = chk_valid && !gen_conflict && !(drain_pend && !gen_empty);
  assign ins_ready = ins_valid && !chk_valid;
  assign acq_ready = acq_valid && !ex_hit && !ex_full;

  rht_gen_table #(.DEPTH(GEN_DEPTH)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_en     (ins_ready),
    .ins_handle (ins_handle),
    .ins_wr     (ins_wr),
    .ins_stamp  (ins_stamp),
    .rel_en     (rel_valid && rel_render),
    .rel_stamp  (rel_stamp),
    .q_handle   (chk_handle),
    .q_wr       (chk_wr),
    .conflict   (gen_conflict),
    .empty      (gen_empty),
    .drop       (gen_drop)
  );

  rht_excl_table #(.DEPTH(EXCL_DEPTH)) u_excl (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_en     (acq_ready),
    .acq_handle (acq_handle),
    .rel_en     (rel_valid && rel_excl),
    .rel_handle (rel_handle),
    .q_handle   (acq_handle),
    .hit        (ex_hit),
    .full       (ex_full)
  );

  rht_ovf_ctrl u_ovf (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_ev     (gen_drop),
    .ovf_clr    (ovf_clr),
    .tbl_empty  (gen_empty),
    .ovf_flag   (ovf_status),
    .drain_pend (drain_pend)
  );
endmodule

// File: tb/sim_res_hazard_tracker.sv
module sim_res_hazard_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int GD = 16;
  localparam int ED = 4;
  localparam int WATCHDOG = 150000;

  logic        clk, rst_n;
  logic        chk_valid, chk_wr, ins_valid, ins_wr, acq_valid;
  logic        rel_valid, rel_render, rel_excl, ovf_clr;
  logic [63:0] chk_handle, ins_handle, acq_handle, rel_handle;
  logic [31:0] ins_stamp, rel_stamp;
  logic        chk_ready, ins_ready, acq_ready, ovf_status;

  res_hazard_tracker #(.GEN_DEPTH(GD), .EXCL_DEPTH(ED)) u0 (
    .clk(clk), .rst_n(rst_n),
    .chk_valid(chk_valid), .chk_handle(chk_handle), .chk_wr(chk_wr), .chk_ready(chk_ready),
    .ins_valid(ins_valid), .ins_handle(ins_handle), .ins_wr(ins_wr), .ins_stamp(ins_stamp),
    .ins_ready(ins_ready),
    .acq_valid(acq_valid), .acq_handle(acq_handle), .acq_ready(acq_ready),
    .rel_valid(rel_valid), .rel_render(rel_render), .rel_stamp(rel_stamp),
    .rel_excl(rel_excl), .rel_handle(rel_handle),
    .ovf_clr(ovf_clr), .ovf_status(ovf_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model
  bit          m_gv [GD];
  logic [63:0] m_gh [GD];
  bit          m_gw [GD];
  logic [31:0] m_gt [GD];
  bit          m_ev [ED];
  logic [63:0] m_eh [ED];
  bit          m_ovf, m_drain;

  logic obs_chk, obs_ins, obs_acq, obs_ovf;

  function automatic int gcount();
    int n = 0;
    for (int i = 0; i < GD; i++) if (m_gv[i]) n++;
    return n;
  endfunction

  function automatic int ecount();
    int n = 0;
    for (int i = 0; i < ED; i++) if (m_ev[i]) n++;
    return n;
  endfunction

  function automatic bit gconf(logic [63:0] h, bit w);
    for (int i = 0; i < GD; i++) if (m_gv[i] && m_gh[i] == h && (m_gw[i] || w)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit ehit(logic [63:0] h);
    for (int i = 0; i < ED; i++) if (m_ev[i] && m_eh[i] == h) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit old_enough(logic [31:0] s, logic [31:0] lim);
    return $signed(s - lim) <= 0;
  endfunction

  task automatic report_summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
      report_summary();
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic idle();
    chk_valid = 0; chk_wr = 0; chk_handle = '0;
    ins_valid = 0; ins_wr = 0; ins_handle = '0; ins_stamp = '0;
    acq_valid = 0; acq_handle = '0;
    rel_valid = 0; rel_render = 0; rel_excl = 0; rel_stamp = '0; rel_handle = '0;
    ovf_clr = 0;
  endtask

  // One clock: compare against model at negedge, then advance model at posedge.
  task automatic cycle();
    bit e_chk, e_ins, e_acq, full_g, full_e;
    int gi, ei;
    @(negedge clk);
    e_chk = chk_valid && !gconf(chk_handle, chk_wr) && !(m_drain && gcount() != 0);
    e_ins = ins_valid && !chk_valid;
    e_acq = acq_valid && !ehit(acq_handle) && ecount() < ED;
    obs_chk = chk_ready; obs_ins = ins_ready; obs_acq = acq_ready; obs_ovf = ovf_status;
    check(chk_ready, e_chk, "R2 chk_ready vs model");
    check(ins_ready, e_ins, "R8 ins_ready vs model");
    check(acq_ready, e_acq, "R9 acq_ready vs model");
    check(ovf_status, m_ovf, "R6 ovf_status vs model");
    full_g = (gcount() == GD);
    full_e = (ecount() == ED);
    gi = -1;
    for (int i = GD - 1; i >= 0; i--) if (!m_gv[i]) gi = i;
    ei = -1;
    for (int i = ED - 1; i >= 0; i--) if (!m_ev[i]) ei = i;
    @(posedge clk);
    #1;
    if (m_drain && gcount() == 0) m_drain = 0;
    if (ovf_clr) m_ovf = 0;
    if (rel_valid && rel_render)
      for (int i = 0; i < GD; i++) if (m_gv[i] && old_enough(m_gt[i], rel_stamp)) m_gv[i] = 0;
    if (rel_valid && rel_excl)
      for (int i = 0; i < ED; i++) if (m_ev[i] && m_eh[i] == rel_handle) m_ev[i] = 0;
    if (e_ins) begin
      if (full_g) begin
        m_ovf = 1; m_drain = 1;
      end else begin
        m_gv[gi] = 1; m_gh[gi] = ins_handle; m_gw[gi] = ins_wr; m_gt[gi] = ins_stamp;
      end
    end
    if (e_acq && !full_e) begin
      m_ev[ei] = 1; m_eh[ei] = acq_handle;
    end
  endtask

  task automatic do_ins(input logic [63:0] h, input bit w, input logic [31:0] s);
    idle(); ins_valid = 1; ins_handle = h; ins_wr = w; ins_stamp = s;
    cycle();
  endtask

  task automatic do_chk(input logic [63:0] h, input bit w);
    idle(); chk_valid = 1; chk_handle = h; chk_wr = w;
    cycle();
  endtask

  task automatic do_acq(input logic [63:0] h);
    idle(); acq_valid = 1; acq_handle = h;
    cycle();
  endtask

  task automatic do_rel(input logic [31:0] s);
    idle(); rel_valid = 1; rel_render = 1; rel_stamp = s;
    cycle();
  endtask

  task automatic do_xrel(input logic [63:0] h);
    idle(); rel_valid = 1; rel_excl = 1; rel_handle = h;
    cycle();
  endtask

  localparam logic [63:0] HA = 64'hA000_0000_0000_1000;
  localparam logic [63:0] HB = 64'hB000_0000_0000_2000;
  localparam logic [63:0] HC = 64'hC000_0000_0000_3000;
  localparam logic [63:0] HD = 64'hD000_0000_0000_4000;
  localparam logic [63:0] HX = 64'h1111_0000_0000_0010;
  localparam logic [63:0] HY = 64'h2222_0000_0000_0020;
  localparam logic [63:0] HZ = 64'h3333_0000_0000_0030;
  localparam logic [63:0] HW = 64'h4444_0000_0000_0040;
  localparam logic [63:0] HV = 64'h5555_0000_0000_0050;
  localparam logic [63:0] HQ = 64'h6666_0000_0000_0060;

  initial begin
    logic [31:0] tick;
    void'($urandom(32'd20240611));
    for (int i = 0; i < GD; i++) m_gv[i] = 0;
    for (int i = 0; i < ED; i++) m_ev[i] = 0;
    m_ovf = 0; m_drain = 0;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    idle(); cycle();
    check(obs_ovf, 1'b0, "R1 overflow clear after reset");
    do_chk(HA, 1);
    check(obs_chk, 1'b1, "R1 check ready on empty table");

    // R2 conflict rules
    do_ins(HA, 0, 32'd10);
    check(obs_ins, 1'b1, "R8 insert taken with no check pending");
    do_chk(HA, 0);
    check(obs_chk, 1'b1, "R2 read against read passes");
    do_chk(HA, 1);
    check(obs_chk, 1'b0, "R2 write against read stalls");
    ins_valid = 1; ins_handle = HB; ins_wr = 1; ins_stamp = 32'd11;
    cycle();
    check(obs_ins, 1'b0, "R8 insert held while check pending");
    do_chk(HB, 1);
    check(obs_chk, 1'b1, "R2 unrelated handle passes");

    // R3/R4 retire by stamp
    idle(); chk_valid = 1; chk_handle = HA; chk_wr = 1; rel_valid = 1; rel_render = 1; rel_stamp = 32'd9;
    cycle();
    check(obs_chk, 1'b0, "R4 stall while entry newer than release");
    rel_stamp = 32'd10;
    cycle();
    check(obs_chk, 1'b0, "R3 still stalled in release cycle");
    rel_valid = 0; rel_render = 0;
    cycle();
    check(obs_chk, 1'b1, "R3 stall ends after removal edge");

    // R4 wraparound
    do_ins(HC, 1, 32'hFFFF_FFF0);
    do_ins(HD, 1, 32'd20);
    do_rel(32'd5);
    do_chk(HC, 1);
    check(obs_chk, 1'b1, "R4 pre-wrap stamp retired");
    do_chk(HD, 1);
    check(obs_chk, 1'b0, "R4 newer entry kept");
    do_rel(32'd20);

    // R5/R7 overflow
    for (int i = 0; i < GD; i++) do_ins(64'h100 + 64'(i), 0, 32'd30);
    do_ins(64'h200, 1, 32'd40);
    check(obs_ins, 1'b1, "R5 overflowing insert still taken");
    do_chk(HB, 0);
    check(obs_ovf, 1'b1, "R5 overflow bit set");
    check(obs_chk, 1'b0, "R7 unrelated check stalls while draining");
    do_rel(32'd35);
    do_chk(64'h200, 1);
    check(obs_chk, 1'b1, "R5 dropped entry not stored, drain done");
    check(obs_ovf, 1'b1, "R6 overflow bit sticky");
    idle(); ovf_clr = 1; cycle();
    idle(); cycle();
    check(obs_ovf, 1'b0, "R6 overflow bit cleared");

    // R9/R10/R11 exclusive table
    do_acq(HX);
    check(obs_acq, 1'b1, "R9 first acquire accepted");
    do_acq(HX);
    check(obs_acq, 1'b0, "R9 duplicate acquire stalls");
    do_acq(HY); do_acq(HZ); do_acq(HW);
    do_acq(HV);
    check(obs_acq, 1'b0, "R11 acquire stalls when full");
    idle(); acq_valid = 1; acq_handle = HV; rel_valid = 1; rel_excl = 1; rel_handle = HX;
    cycle();
    check(obs_acq, 1'b0, "R10 acquire stalled in release cycle");
    do_acq(HV);
    check(obs_acq, 1'b1, "R10 slot freed by exact release");
    do_acq(HY);
    check(obs_acq, 1'b0, "R10 other exclusive entries kept");

    // R12 independence
    do_chk(HV, 1);
    check(obs_chk, 1'b1, "R12 exclusive entry does not stall check");
    do_xrel(HW);
    do_ins(HQ, 1, 32'd50);
    do_acq(HQ);
    check(obs_acq, 1'b1, "R12 general entry does not stall acquire");

    // constrained random mix
    tick = 32'd1000;
    for (int n = 0; n < 3000; n++) begin
      idle();
      chk_valid  = ($urandom % 10) < 4;
      chk_handle = 64'hF00 + 64'($urandom % 6);
      chk_wr     = $urandom % 2;
      ins_valid  = ($urandom % 10) < 4;
      ins_handle = 64'hF00 + 64'($urandom % 6);
      ins_wr     = $urandom % 2;
      ins_stamp  = tick + ($urandom % 8);
      acq_valid  = ($urandom % 10) < 3;
      acq_handle = 64'hE00 + 64'($urandom % 6);
      rel_valid  = ($urandom % 100) < 15;
      rel_render = ($urandom % 10) < 7;
      rel_excl   = $urandom % 2;
      rel_stamp  = tick - ($urandom % 16);
      rel_handle = 64'hE00 + 64'($urandom % 6);
      ovf_clr    = ($urandom % 100) < 5;
      cycle();
      tick = tick + 1;
    end

    idle();
    report_summary();
    $finish;
  end
endmodule